// File: doc/BRIEF.md
# CPU Halt and Wake Control Window

This block gives one processor core a small register window on a simple memory-mapped read/write bus. It lets the core park itself until something external needs attention. Software stores to the halt register. That single store stops the step enable to the core and loads a new interrupt level. The level is only held and presented here; no comparison against it is made in this block.

The block latches external interrupt arrivals, numbered 0 to 15, into a pending vector. Any valid arrival while parked restarts the core. The core acknowledges an interrupt through a separate take port, which clears the matching pending bit. A free-running cycle counter runs beside the halt state. Parked time is added to a halted-total counter at each wake, so software can read how many cycles the core actually ran. The lower part of the window is read-only: it holds identification and accounting values, and a store into it is refused with an error response.

Top module: `halt_wake_ctl`

## Requirements
- R1: After reset, the following all read zero: the halt flag, interrupt level, pending vector, invalid flag, response valid and error. Step enable is 1.
- R2: A store to offset 0xA0 (at or above the read-only limit) sets the halt flag on the next cycle, and core_step_en drops. The same store loads wdata[3:0] into the interrupt level. A read of 0xA0 returns the level in bits 3:0 and the halt flag in bit 8.
- R3: An arrival with irq_num below 16 sets pending bit irq_num on the next cycle. Offset 0x10 reads the pending vector.
- R4: A valid arrival while halted clears the halt flag on the next cycle, and step enable returns.
- R5: An arrival with irq_num of 16 or more pulses irq_invalid for one cycle. It leaves the pending vector and the halt flag unchanged.
- R6: A take of number n clears pending bit n. A new arrival of the same number in the same cycle leaves the bit set.
- R7: If a halt store and a valid arrival occur in the same cycle, the core stays running. The pending bit is still set and the level is still loaded.
- R8: A store to any offset below 0x80 returns rsp_err with its response and changes no state.
- R9: Every request gets rsp_valid exactly one cycle later. The read data is zero-extended to 32 bits. Undecoded offsets and the write-only clear at 0x90 read as zero.
- R10: Offset 0x04 reads the cycles since reset. Offset 0x14 reads the cycle count captured by the last halting store. Offset 0x08 reads the halted total, which grows at each wake by the wake count minus the captured count.
- R11: Offset 0x0C reads run cycles. While running, this is the elapsed count minus the halted total. While halted it does not advance.
- R12: Offset 0x84 is a 32-bit read/write data register. A store to 0xC0 loads the 32-bit fast-interrupt register. Any store to 0x90 clears that register.
- R13: Offset 0x00 reads the CPU_ID parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 for store, 0 for load |
| bus_addr | input | 8 | Byte offset in the window |
| bus_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response, one cycle after bus_req |
| rsp_err | output | 1 | Store into the read-only range refused |
| rsp_rdata | output | 32 | Load data, zero otherwise |
| irq_valid | input | 1 | External interrupt arrival |
| irq_num | input | 5 | Arrival number, 0 to 15 valid |
| irq_take | input | 1 | Core takes an interrupt |
| irq_take_num | input | 4 | Number being taken |
| core_step_en | output | 1 | Core may advance |
| halted | output | 1 | Halt flag |
| irq_level | output | 4 | Processor interrupt level |
| irq_invalid | output | 1 | Out-of-range arrival seen last cycle |
| pending | output | 16 | Pending interrupt vector |

## Verification
The assertions assume that reset is applied before the first clock. They also assume that bus and interrupt inputs are stable around the sampling edge, and that take numbers are always in range. The stimulus drives every input shortly after a rising edge, holds it for a full cycle and keeps take numbers below 16. Out-of-range behaviour is reached only through irq_num values of 16 and above, which are legal inputs. A behavioural model in the bench predicts every output on every cycle, including the same-cycle races between a halt store and an arrival and between a take and an arrival.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
    localparam int OFS_W  = 8;
    localparam int DATA_W = 32;

    localparam logic [OFS_W-1:0] RO_LIMIT    = 8'h80;
    localparam logic [OFS_W-1:0] OFS_ID      = 8'h00;
    localparam logic [OFS_W-1:0] OFS_ELAPSED = 8'h04;
    localparam logic [OFS_W-1:0] OFS_HTOTAL  = 8'h08;
    localparam logic [OFS_W-1:0] OFS_RUN     = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_PEND    = 8'h10;
    localparam logic [OFS_W-1:0] OFS_STAMP   = 8'h14;
    localparam logic [OFS_W-1:0] OFS_DATA    = 8'h84;
    localparam logic [OFS_W-1:0] OFS_FCLR    = 8'h90;
    localparam logic [OFS_W-1:0] OFS_HALT    = 8'hA0;
    localparam logic [OFS_W-1:0] OFS_FAST    = 8'hC0;

    typedef enum logic [3:0] {
        RG_NONE, RG_ID, RG_ELAPSED, RG_HTOTAL, RG_RUN, RG_PEND,
        RG_STAMP, RG_DATA, RG_FCLR, RG_HALT, RG_FAST
    } reg_sel_e;
endpackage

// File: rtl/hwc_decode.sv
module hwc_decode
    import hwc_pkg::*;
(
    input  logic [OFS_W-1:0] ofs_i,
    output reg_sel_e         sel_o,
    output logic             ro_o
);
    always_comb begin
        ro_o = (ofs_i < RO_LIMIT);
        case (ofs_i)
            OFS_ID:      sel_o = RG_ID;
            OFS_ELAPSED: sel_o = RG_ELAPSED;
            OFS_HTOTAL:  sel_o = RG_HTOTAL;
            OFS_RUN:     sel_o = RG_RUN;
            OFS_PEND:    sel_o = RG_PEND;
            OFS_STAMP:   sel_o = RG_STAMP;
            OFS_DATA:    sel_o = RG_DATA;
            OFS_FCLR:    sel_o = RG_FCLR;
            OFS_HALT:    sel_o = RG_HALT;
            OFS_FAST:    sel_o = RG_FAST;
            default:     sel_o = RG_NONE;
        endcase
    end
endmodule

// File: rtl/hwc_pending.sv
module hwc_pending #(
    parameter int NIRQ  = 16,
    parameter int NUM_W = 5,
    localparam int IDX_W = $clog2(NIRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_v_i,
    input  logic [NUM_W-1:0] irq_num_i,
    input  logic             take_v_i,
    input  logic [IDX_W-1:0] take_num_i,
    output logic [NIRQ-1:0]  pend_o,
    output logic             irq_ok_o,
    output logic             irq_bad_o
);
    typedef struct packed {
        logic [NIRQ-1:0] pend;
        logic            bad;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [NIRQ-1:0] set_vec, clr_vec;

    assign irq_ok_o = irq_v_i && (irq_num_i < NUM_W'(NIRQ));

    for (genvar i = 0; i < NIRQ; i++) begin : g_bit
        assign set_vec[i] = irq_ok_o && (irq_num_i == NUM_W'(i));
        assign clr_vec[i] = take_v_i && (take_num_i == IDX_W'(i));
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_vec) | set_vec;
        st_d.bad  = irq_v_i && !irq_ok_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o    = st_q.pend;
    assign irq_bad_o = st_q.bad;

    // R3: an accepted arrival shows up in the vector next cycle
    p_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ok_o |=> pend_o[$past(irq_num_i[IDX_W-1:0])]);
    // R5: an out-of-range arrival alone leaves the vector untouched
    p_bad_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_v_i && !irq_ok_o && !take_v_i) |=> $stable(pend_o));
    // R6: a take without a same-number arrival clears the bit
    p_take_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_v_i && !(irq_ok_o && irq_num_i[IDX_W-1:0] == take_num_i))
        |=> !pend_o[$past(take_num_i)]);
endmodule

// File: rtl/hwc_cycles.sv
module hwc_cycles #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_enter_i,
    input  logic             wake_i,
    input  logic             halted_i,
    output logic [CNT_W-1:0] elapsed_o,
    output logic [CNT_W-1:0] total_o,
    output logic [CNT_W-1:0] stamp_o,
    output logic [CNT_W-1:0] run_o
);
    typedef struct packed {
        logic [CNT_W-1:0] elapsed;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] stamp;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.elapsed = st_q.elapsed + CNT_W'(1);
        if (halt_enter_i) st_d.stamp = st_q.elapsed;
        if (wake_i)       st_d.total = st_q.total + (st_q.elapsed - st_q.stamp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign elapsed_o = st_q.elapsed;
    assign total_o   = st_q.total;
    assign stamp_o   = st_q.stamp;
    assign run_o     = halted_i ? (st_q.stamp - st_q.total)
                                : (st_q.elapsed - st_q.total);

    // R10: the halted total only moves on a wake
    p_total_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_i |=> $stable(total_o));
    // R10: the halting store captures the free-running count
    p_stamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_enter_i |=> stamp_o == $past(elapsed_o));
    // R11: run cycles stand still across a parked stretch
    p_run_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_i && $past(halted_i)) |-> $stable(run_o));
endmodule

// File: rtl/halt_wake_ctl.sv
module halt_wake_ctl
    import hwc_pkg::*;
#(
    parameter int CPU_ID = 3,
    parameter int NIRQ   = 16,
    parameter int NUM_W  = 5,
    parameter int LVL_W  = 4,
    parameter int CNT_W  = 32,
    localparam int IDX_W = $clog2(NIRQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              irq_valid,
    input  logic [NUM_W-1:0]  irq_num,
    input  logic              irq_take,
    input  logic [IDX_W-1:0]  irq_take_num,
    output logic              core_step_en,
    output logic              halted,
    output logic [LVL_W-1:0]  irq_level,
    output logic              irq_invalid,
    output logic [NIRQ-1:0]   pending
);
    localparam int HALT_BIT = 8;

    typedef struct packed {
        logic              halted;
        logic [LVL_W-1:0]  level;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] fast;
        logic              rv;
        logic              rerr;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;
    reg_sel_e sel;
    logic ro, irq_ok;
    logic wr, wr_ok, ro_bad, halt_wr, halt_enter, wake;
    logic [CNT_W-1:0] elapsed, total, stamp, run;
    logic [DATA_W-1:0] rmux;

    hwc_decode u_dec (.ofs_i(bus_addr), .sel_o(sel), .ro_o(ro));

    hwc_pending #(.NIRQ(NIRQ), .NUM_W(NUM_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .irq_v_i(irq_valid), .irq_num_i(irq_num),
        .take_v_i(irq_take), .take_num_i(irq_take_num),
        .pend_o(pending), .irq_ok_o(irq_ok), .irq_bad_o(irq_invalid)
    );

    hwc_cycles #(.CNT_W(CNT_W)) u_cyc (
        .clk(clk), .rst_n(rst_n),
        .halt_enter_i(halt_enter), .wake_i(wake), .halted_i(st_q.halted),
        .elapsed_o(elapsed), .total_o(total), .stamp_o(stamp), .run_o(run)
    );

    always_comb begin
        rmux = '0;
        case (sel)
            RG_ID:      rmux = DATA_W'(CPU_ID);
            RG_ELAPSED: rmux = DATA_W'(elapsed);
            RG_HTOTAL:  rmux = DATA_W'(total);
            RG_RUN:     rmux = DATA_W'(run);
            RG_PEND:    rmux = DATA_W'(pending);
            RG_STAMP:   rmux = DATA_W'(stamp);
            RG_DATA:    rmux = st_q.data;
            RG_FAST:    rmux = st_q.fast;
            RG_HALT: begin
                rmux[LVL_W-1:0] = st_q.level;
                rmux[HALT_BIT]  = st_q.halted;
            end
            default:    rmux = '0;
        endcase
    end

    always_comb begin
        wr         = bus_req && bus_we;
        ro_bad     = wr && ro;
        wr_ok      = wr && !ro;
        halt_wr    = wr_ok && (sel == RG_HALT);
        wake       = st_q.halted && irq_ok;
        halt_enter = halt_wr && !irq_ok && !st_q.halted;

        st_d = st_q;
        if (irq_ok)       st_d.halted = 1'b0;
        else if (halt_wr) st_d.halted = 1'b1;
        if (halt_wr) st_d.level = bus_wdata[LVL_W-1:0];
        if (wr_ok && sel == RG_DATA) st_d.data = bus_wdata;
        if (wr_ok && sel == RG_FAST) st_d.fast = bus_wdata;
        if (wr_ok && sel == RG_FCLR) st_d.fast = '0;
        st_d.rv    = bus_req;
        st_d.rerr  = ro_bad;
        st_d.rdata = (bus_req && !bus_we) ? rmux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.rv;
    assign rsp_err      = st_q.rerr;
    assign rsp_rdata    = st_q.rdata;
    assign halted       = st_q.halted;
    assign core_step_en = !st_q.halted;
    assign irq_level    = st_q.level;

    // R2: the halt flag only rises after an accepted halting store
    p_halt_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(halt_wr));
    // R2: the level follows the low bits of the halting store
    p_level_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wr |=> irq_level == $past(bus_wdata[LVL_W-1:0]));
    // R4: a valid arrival while parked restarts the core
    p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && irq_ok) |=> core_step_en);
    // R7: the arrival wins over a simultaneous halting store
    p_race_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_wr && irq_ok) |=> !halted);
    // R8: a refused store leaves the writable state alone
    p_ro_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ro) |=> rsp_err && $stable(irq_level) && $stable(st_q.data) && $stable(st_q.fast));
    // R9: response exactly one cycle after each request
    p_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> rsp_valid);
    p_norsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !rsp_valid);
endmodule

// File: tb/halt_wake_ctl_bench.sv
module halt_wake_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_req = 1'b0, in_we = 1'b0;
    logic [7:0]  in_addr = '0;
    logic [31:0] in_wdata = '0;
    logic        in_irq_v = 1'b0;
    logic [4:0]  in_irq_num = '0;
    logic        in_take = 1'b0;
    logic [3:0]  in_take_num = '0;

    logic        rsp_valid, rsp_err, core_step_en, halted, irq_invalid;
    logic [31:0] rsp_rdata;
    logic [3:0]  irq_level;
    logic [15:0] pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic        m_halted = 0, m_rv = 0, m_rerr = 0, m_bad = 0;
    logic [3:0]  m_level = 0;
    logic [15:0] m_pend = 0;
    logic [31:0] m_elapsed = 0, m_total = 0, m_stamp = 0, m_data = 0, m_fast = 0, m_rdata = 0;
    string       m_tag = "R9";

    halt_wake_ctl u_halt_wake_ctl (
        .clk(clk), .rst_n(rst_n),
        .bus_req(in_req), .bus_we(in_we), .bus_addr(in_addr), .bus_wdata(in_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .irq_valid(in_irq_v), .irq_num(in_irq_num),
        .irq_take(in_take), .irq_take_num(in_take_num),
        .core_step_en(core_step_en), .halted(halted), .irq_level(irq_level),
        .irq_invalid(irq_invalid), .pending(pending)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a);
        case (a)
            8'h00: return 32'd3;                       // R13
            8'h04: return m_elapsed;                   // R10
            8'h08: return m_total;
            8'h0C: return m_halted ? m_stamp - m_total : m_elapsed - m_total; // R11
            8'h10: return {16'h0, m_pend};
            8'h14: return m_stamp;
            8'h84: return m_data;                      // R12
            8'hC0: return m_fast;
            8'hA0: return {23'h0, m_halted, 4'h0, m_level};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h00: return "R13";
            8'h04, 8'h08, 8'h14: return "R10";
            8'h0C: return "R11";
            8'h10: return "R3";
            8'h84, 8'h90, 8'hC0: return "R12";
            8'hA0: return "R2";
            default: return "R9";
        endcase
    endfunction

    task automatic model_edge();
        logic ok, wr, wok, hw;
        ok  = in_irq_v && (in_irq_num < 5'd16);
        wr  = in_req && in_we;
        wok = wr && (in_addr >= 8'h80);
        hw  = wok && (in_addr == 8'hA0);
        m_rdata = (in_req && !in_we) ? model_read(in_addr) : 32'h0;
        m_tag   = tag_of(in_addr);
        m_rv    = in_req;
        m_rerr  = wr && (in_addr < 8'h80);
        if (m_halted && ok) m_total = m_total + (m_elapsed - m_stamp);
        if (hw && !ok && !m_halted) m_stamp = m_elapsed;
        if (ok) m_halted = 1'b0;
        else if (hw) m_halted = 1'b1;
        if (hw) m_level = in_wdata[3:0];
        if (wok && in_addr == 8'h84) m_data = in_wdata;
        if (wok && in_addr == 8'hC0) m_fast = in_wdata;
        if (wok && in_addr == 8'h90) m_fast = 32'h0;
        if (in_take) m_pend[in_take_num] = 1'b0;
        if (ok) m_pend[in_irq_num[3:0]] = 1'b1;
        m_bad = in_irq_v && !ok;
        m_elapsed = m_elapsed + 1;
    endtask

    task automatic compare_all();
        chk("R9 rsp_valid", {31'h0, rsp_valid}, {31'h0, m_rv});
        chk("R8 rsp_err", {31'h0, rsp_err}, {31'h0, m_rerr});
        chk({m_tag, " rdata"}, rsp_rdata, m_rdata);
        chk("R4 halted", {31'h0, halted}, {31'h0, m_halted});
        chk("R2 step_en", {31'h0, core_step_en}, {31'h0, !m_halted});
        chk("R2 level", {28'h0, irq_level}, {28'h0, m_level});
        chk("R3 pending", {16'h0, pending}, {16'h0, m_pend});
        chk("R5 invalid", {31'h0, irq_invalid}, {31'h0, m_bad});
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #2;
        compare_all();
    endtask

    task automatic clear_in();
        in_req = 0; in_we = 0; in_irq_v = 0; in_take = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic bus(logic we, logic [7:0] a, logic [31:0] d);
        in_req = 1; in_we = we; in_addr = a; in_wdata = d;
        step();
        clear_in();
    endtask

    task automatic irq(logic [4:0] n);
        in_irq_v = 1; in_irq_num = n;
        step();
        clear_in();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state
        chk("R1 halted", {31'h0, halted}, 32'h0);
        chk("R1 step_en", {31'h0, core_step_en}, 32'h1);
        chk("R1 pending", {16'h0, pending}, 32'h0);
        chk("R1 level", {28'h0, irq_level}, 32'h0);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        idle(3);
        // R13, R10, R9: identification, counters, undecoded zero
        bus(0, 8'h00, 0); bus(0, 8'h04, 0); bus(0, 8'h30, 0); bus(0, 8'h90, 0);
        bus(0, 8'h0C, 0); idle(1);
        // R12: data, fast load, fast clear
        bus(1, 8'h84, 32'hDEADBEEF); bus(0, 8'h84, 0);
        bus(1, 8'hC0, 32'h1234_5678); bus(0, 8'hC0, 0);
        bus(1, 8'h90, 32'h0); bus(0, 8'hC0, 0);
        // R8: stores into the read-only range are refused
        bus(1, 8'h04, 32'hFFFF_FFFF); bus(1, 8'h00, 32'h55); bus(1, 8'h7C, 32'h1);
        bus(0, 8'h04, 0); bus(0, 8'h00, 0);
        // R3: arrivals while running
        irq(5'd3); irq(5'd15); irq(5'd0); bus(0, 8'h10, 0);
        // R6: take clears, same-number arrival wins
        in_take = 1; in_take_num = 4'd3; step(); clear_in();
        in_take = 1; in_take_num = 4'd15; in_irq_v = 1; in_irq_num = 5'd15; step(); clear_in();
        chk("R6 same-cycle arrival keeps bit", {31'h0, pending[15]}, 32'h1);
        in_take = 1; in_take_num = 4'd0; step(); clear_in();
        // R5: out-of-range arrival
        irq(5'd20); idle(1);
        // R2: park with level 5, then accounting while halted (R11)
        bus(1, 8'hA0, 32'h0000_0005); idle(2);
        bus(0, 8'h0C, 0); idle(6); bus(0, 8'h0C, 0);
        bus(0, 8'h14, 0); bus(0, 8'hA0, 0);
        irq(5'd17); idle(2);
        chk("R5 no wake on invalid", {31'h0, halted}, 32'h1);
        // R4: valid arrival wakes
        irq(5'd7); bus(0, 8'h08, 0); bus(0, 8'h0C, 0); idle(3); bus(0, 8'h0C, 0);
        // R7: halt store and arrival in the same cycle
        in_req = 1; in_we = 1; in_addr = 8'hA0; in_wdata = 32'h9;
        in_irq_v = 1; in_irq_num = 5'd9; step(); clear_in();
        chk("R7 race keeps running", {31'h0, halted}, 32'h0);
        idle(2);
        // R2: only low level bits are loaded; second park and wake (R10)
        bus(1, 8'hA0, 32'hFFFF_FFFE); idle(11);
        bus(0, 8'hA0, 0);
        irq(5'd0); bus(0, 8'h08, 0); bus(0, 8'h14, 0); bus(0, 8'h04, 0);
        // R9: back-to-back loads and an undecoded store
        bus(1, 8'hE4, 32'hABCD); bus(0, 8'hE4, 0); bus(0, 8'h10, 0); bus(0, 8'h0C, 0);
        idle(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule